// File: doc/BRIEF.md
# Next-PC and Trap Sequencer

This block owns the program counter of a 32-bit, word-addressed processor. Each cycle it can accept one decoded instruction: the major opcode, the extended opcode, the first register field, the 22-bit address field, and the current values of the register named by that field and of register 30. It selects the following PC for sequential flow, jumps, conditional branches, calls and returns. For a call it produces a link write for the register file.

Trap instructions take their trap number from the first register field. One trap number halts the machine. Two others send register 30 out as an integer or as a character on a print stream.

Instructions arrive on a valid/ready handshake. `instr_ready` drops while the machine is halted, and while a print result is waiting for its consumer. The print stream is also valid/ready. Once `print_valid` is high, `print_data` and `print_is_char` stay unchanged until a cycle in which `print_ready` is high. If the consumer holds `print_ready` high, each print produces a one-cycle pulse. While a print is stalled, no instruction is accepted and the PC does not move.

Top module: `npc_trap_seq`

## Requirements
- R1: After reset, `pc` is 0, `halt` is 0, `print_valid` is 0 and `instr_ready` is 1.
- R2: An accepted instruction that is neither a control-flow instruction nor a trap (for example opcode 0, nop, or any ALU opcode) advances `pc` by 1 on the next edge. In a cycle with no accepted instruction, `pc` holds its value.
- R3: Opcode 6 (jump) loads `pc` with the 22-bit address field, sign-extended to 32 bits.
- R4: Opcode 7 (call) loads `pc` with the sign-extended address field. In its accept cycle it raises `link_we`, with `link_idx` equal to the r1 field and `link_val` equal to `pc`+1. When the r1 field is 0, `link_we` stays low.
- R5: Opcode 8 branches to the sign-extended address when `r1_val` is nonzero. Opcode 9 branches when `r1_val` is zero. When the branch is not taken, `pc` advances by 1.
- R6: Opcode 31 with extended opcode 18 (return) loads `pc` with `r1_val`.
- R7: Opcode 31 with extended opcode 19 and r1 field 0 sets `halt` on the next edge. `pc` keeps the trap's own address and stays frozen, and `instr_ready` stays low until reset.
- R8: Opcode 31 with extended opcode 19 and r1 field 1 or 2 raises `print_valid` on the next edge. `print_data` equals the `r30_val` that was presented, and `print_is_char` is 0 for field 1 (integer) and 1 for field 2 (character). `pc` advances by 1.
- R9: While `print_valid` is high and `print_ready` is low, `print_data` and `print_is_char` hold, `instr_ready` is low and `pc` does not change. `print_valid` falls after the first edge at which `print_ready` is high.
- R10: The following are undefined: opcodes 25 to 30, opcode 31 with extended opcode 23 or above, and a trap with r1 field above 2. An accepted undefined instruction raises `illegal` in its accept cycle and advances `pc` by 1, with no link write, print or halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | A decoded instruction is presented |
| instr_ready | output | 1 | The sequencer can take an instruction this cycle |
| opcode | input | 5 | Major opcode |
| xop | input | 12 | Extended opcode, meaningful for opcode 31 |
| r1_idx | input | 5 | First register field; also the trap number |
| addr_field | input | 22 | Address field, signed |
| r1_val | input | 32 | Value of the register named by r1_idx |
| r30_val | input | 32 | Value of register 30 |
| pc | output | 32 | Current program counter |
| link_we | output | 1 | Link register write enable |
| link_idx | output | 5 | Link register index |
| link_val | output | 32 | Return address to write |
| halt | output | 1 | Machine halted |
| illegal | output | 1 | Undefined instruction accepted this cycle |
| print_valid | output | 1 | Print item available |
| print_ready | input | 1 | Print consumer accepts the item |
| print_data | output | 32 | Value to print |
| print_is_char | output | 1 | 1 means print as a character, 0 as an integer |

## Verification
The bench uses address fields with the top bit set. A design that zero-extends the address field would land at a small positive address instead of near the top of memory. It calls with r1 field 0, which would expose a link write to the hardwired zero register. It also checks that the link value is the following instruction, not the call's own address.

For the branches, the bench runs both taken and untaken cases of each polarity, so a swapped test condition is caught. It holds `print_ready` low across several cycles after a trap. A sequencer that ignored back-pressure would drop the item, let its data change, or move the PC.

After halt, the bench keeps offering instructions and checks that the PC neither advances nor moves past the trap. It also presents trap number 3 and the extended opcode one past the last defined one, to catch decode boundaries that are off by one.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int OPW  = 5;
  localparam int XOPW = 12;
  localparam int RIW  = 5;

  localparam logic [OPW-1:0]  OP_JUMP   = 5'd6;
  localparam logic [OPW-1:0]  OP_CALL   = 5'd7;
  localparam logic [OPW-1:0]  OP_BR_NZ  = 5'd8;
  localparam logic [OPW-1:0]  OP_BR_Z   = 5'd9;
  localparam logic [OPW-1:0]  OP_UNDEF_LO = 5'd25;
  localparam logic [OPW-1:0]  OP_UNDEF_HI = 5'd30;
  localparam logic [OPW-1:0]  OP_EXT    = 5'd31;
  localparam logic [XOPW-1:0] XO_RETURN = 12'd18;
  localparam logic [XOPW-1:0] XO_TRAP   = 12'd19;
  localparam logic [XOPW-1:0] XO_FIRST_UNDEF = 12'd23;

  typedef enum logic [3:0] {
    K_SEQ, K_JUMP, K_CALL, K_BR_NZ, K_BR_Z, K_RETURN,
    K_STOP, K_PRINT_INT, K_PRINT_CHR, K_UNDEF
  } flow_kind_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [OPW-1:0]  opcode,
  input  logic [XOPW-1:0] xop,
  input  logic [RIW-1:0]  r1_idx,
  output flow_kind_e      kind
);
  always_comb begin
    kind = K_SEQ;
    if (opcode == OP_JUMP)                             kind = K_JUMP;
    else if (opcode == OP_CALL)                        kind = K_CALL;
    else if (opcode == OP_BR_NZ)                       kind = K_BR_NZ;
    else if (opcode == OP_BR_Z)                        kind = K_BR_Z;
    else if (opcode >= OP_UNDEF_LO && opcode <= OP_UNDEF_HI) kind = K_UNDEF;
    else if (opcode == OP_EXT) begin
      if (xop == XO_RETURN) kind = K_RETURN;
      else if (xop == XO_TRAP) begin
        case (r1_idx)
          5'd0:    kind = K_STOP;
          5'd1:    kind = K_PRINT_INT;
          5'd2:    kind = K_PRINT_CHR;
          default: kind = K_UNDEF;
        endcase
      end
      else if (xop >= XO_FIRST_UNDEF) kind = K_UNDEF;
    end
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 22
) (
  input  flow_kind_e       kind,
  input  logic [XLEN-1:0]  pc,
  input  logic [AW-1:0]    addr_field,
  input  logic [XLEN-1:0]  r1_val,
  output logic [XLEN-1:0]  next_pc,
  output logic [XLEN-1:0]  seq_pc
);
  localparam logic [XLEN-1:0] ONE = XLEN'(1);
  logic [XLEN-1:0] abs_target;
  logic            r1_zero;

  assign seq_pc     = pc + ONE;
  assign abs_target = {{(XLEN-AW){addr_field[AW-1]}}, addr_field};
  assign r1_zero    = (r1_val == '0);

  always_comb begin
    case (kind)
      K_JUMP, K_CALL: next_pc = abs_target;
      K_BR_NZ:        next_pc = r1_zero ? seq_pc : abs_target;
      K_BR_Z:         next_pc = r1_zero ? abs_target : seq_pc;
      K_RETURN:       next_pc = r1_val;
      K_STOP:         next_pc = pc;
      default:        next_pc = seq_pc;
    endcase
  end
endmodule

// File: rtl/npc_print.sv
module npc_print #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            load_is_char,
  input  logic [XLEN-1:0] load_data,
  input  logic            out_ready,
  output logic            out_valid,
  output logic [XLEN-1:0] out_data,
  output logic            out_is_char
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_is_char <= 1'b0;
    end else if (load) begin
      out_valid   <= 1'b1;
      out_data    <= load_data;
      out_is_char <= load_is_char;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  a_r9_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_is_char));
endmodule

// File: rtl/npc_trap_seq.sv
module npc_trap_seq
  import npc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 22
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  output logic            instr_ready,
  input  logic [4:0]      opcode,
  input  logic [11:0]     xop,
  input  logic [4:0]      r1_idx,
  input  logic [AW-1:0]   addr_field,
  input  logic [XLEN-1:0] r1_val,
  input  logic [XLEN-1:0] r30_val,
  output logic [XLEN-1:0] pc,
  output logic            link_we,
  output logic [4:0]      link_idx,
  output logic [XLEN-1:0] link_val,
  output logic            halt,
  output logic            illegal,
  output logic            print_valid,
  input  logic            print_ready,
  output logic [XLEN-1:0] print_data,
  output logic            print_is_char
);
  flow_kind_e      kind;
  logic [XLEN-1:0] pc_q, next_pc, seq_pc;
  logic            halt_q, accept, print_stall;

  npc_decode u_dec (
    .opcode (opcode), .xop (xop), .r1_idx (r1_idx), .kind (kind)
  );

  npc_target #(.XLEN(XLEN), .AW(AW)) u_tgt (
    .kind (kind), .pc (pc_q), .addr_field (addr_field), .r1_val (r1_val),
    .next_pc (next_pc), .seq_pc (seq_pc)
  );

  assign print_stall = print_valid && !print_ready;
  assign instr_ready = !halt_q && !print_stall;
  assign accept      = instr_valid && instr_ready;

  npc_print #(.XLEN(XLEN)) u_prt (
    .clk (clk), .rst_n (rst_n),
    .load (accept && (kind == K_PRINT_INT || kind == K_PRINT_CHR)),
    .load_is_char (kind == K_PRINT_CHR), .load_data (r30_val),
    .out_ready (print_ready), .out_valid (print_valid),
    .out_data (print_data), .out_is_char (print_is_char)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      halt_q <= 1'b0;
    end else if (accept) begin
      pc_q <= next_pc;
      if (kind == K_STOP) halt_q <= 1'b1;
    end
  end

  assign pc       = pc_q;
  assign halt     = halt_q;
  assign link_we  = accept && (kind == K_CALL) && (r1_idx != '0);
  assign link_idx = r1_idx;
  assign link_val = seq_pc;
  assign illegal  = accept && (kind == K_UNDEF);

  a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);
  a_r7_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> $stable(pc));
  a_r4_call_target: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |=> pc == $past({{(XLEN-AW){addr_field[AW-1]}}, addr_field}));
  a_r10_undef_steps: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> pc == $past(pc) + XLEN'(1));
  a_r9_no_move_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    print_valid && !print_ready |=> $stable(pc));
endmodule

// File: tb/tb_npc_trap_seq.sv
module tb_npc_trap_seq;
  logic        clk = 0, rst_n = 0;
  logic        instr_valid = 0, print_ready = 1;
  logic [4:0]  opcode = 0, r1_idx = 0;
  logic [11:0] xop = 0;
  logic [21:0] addr_field = 0;
  logic [31:0] r1_val = 0, r30_val = 0;
  logic        instr_ready, link_we, halt, illegal, print_valid, print_is_char;
  logic [4:0]  link_idx;
  logic [31:0] pc, link_val, print_data;
  int checks = 0, errors = 0;
  logic        s_we, s_ill;
  logic [4:0]  s_idx;
  logic [31:0] s_val;

  always #2 clk = ~clk;

  npc_trap_seq dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .opcode(opcode), .xop(xop), .r1_idx(r1_idx), .addr_field(addr_field),
    .r1_val(r1_val), .r30_val(r30_val), .pc(pc), .link_we(link_we),
    .link_idx(link_idx), .link_val(link_val), .halt(halt), .illegal(illegal),
    .print_valid(print_valid), .print_ready(print_ready), .print_data(print_data),
    .print_is_char(print_is_char)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, sample comb outputs, pass one edge, return at negedge
  task automatic issue(logic [4:0] op, logic [11:0] xo, logic [4:0] r1,
                       logic [21:0] ad, logic [31:0] rv, logic [31:0] r30);
    opcode = op; xop = xo; r1_idx = r1; addr_field = ad; r1_val = rv; r30_val = r30;
    instr_valid = 1;
    #1;
    s_we = link_we; s_ill = illegal; s_idx = link_idx; s_val = link_val;
    @(posedge clk); @(negedge clk);
    instr_valid = 0;
  endtask

  task automatic t_reset;
    check("R1 pc", pc, 0);
    check("R1 halt", {31'b0, halt}, 0);
    check("R1 print_valid", {31'b0, print_valid}, 0);
    check("R1 instr_ready", {31'b0, instr_ready}, 1);
  endtask

  task automatic t_seq;
    issue(5'd0, 0, 0, 0, 0, 0);
    check("R2 nop step", pc, 1);
    issue(5'd10, 0, 3, 22'h3FFFFF, 0, 0);
    check("R2 alu step", pc, 2);
    @(posedge clk); @(negedge clk);
    check("R2 idle hold", pc, 2);
  endtask

  task automatic t_jump;
    issue(5'd6, 0, 0, 22'd100, 0, 0);
    check("R3 jump positive", pc, 100);
    issue(5'd6, 0, 0, 22'h200000, 0, 0);
    check("R3 jump sign-extended", pc, 32'hFFE00000);
  endtask

  task automatic t_call;
    issue(5'd6, 0, 0, 22'd40, 0, 0);
    issue(5'd7, 0, 5'd5, 22'd200, 0, 0);
    check("R4 link_we", {31'b0, s_we}, 1);
    check("R4 link_idx", {27'b0, s_idx}, 5);
    check("R4 link_val", s_val, 41);
    check("R4 call target", pc, 200);
    issue(5'd7, 0, 5'd0, 22'h3FFFF0, 0, 0);
    check("R4 r0 no link", {31'b0, s_we}, 0);
    check("R4 negative target", pc, 32'hFFFFFFF0);
  endtask

  task automatic t_branch;
    issue(5'd6, 0, 0, 22'd10, 0, 0);
    issue(5'd8, 0, 1, 22'd50, 32'h8000_0000, 0);
    check("R5 nz taken", pc, 50);
    issue(5'd8, 0, 1, 22'd90, 0, 0);
    check("R5 nz untaken", pc, 51);
    issue(5'd9, 0, 1, 22'd70, 0, 0);
    check("R5 z taken", pc, 70);
    issue(5'd9, 0, 1, 22'd90, 32'd1, 0);
    check("R5 z untaken", pc, 71);
  endtask

  task automatic t_return;
    issue(5'd31, 12'd18, 3, 22'd7, 32'h1234_5678, 0);
    check("R6 return", pc, 32'h1234_5678);
  endtask

  task automatic t_print;
    issue(5'd6, 0, 0, 22'd300, 0, 0);
    print_ready = 1;
    issue(5'd31, 12'd19, 5'd1, 0, 0, 32'hDEAD_0001);
    check("R8 int valid", {31'b0, print_valid}, 1);
    check("R8 int data", print_data, 32'hDEAD_0001);
    check("R8 int type", {31'b0, print_is_char}, 0);
    check("R8 pc step", pc, 301);
    @(posedge clk); @(negedge clk);
    check("R8 single pulse", {31'b0, print_valid}, 0);
    print_ready = 0;
    issue(5'd31, 12'd19, 5'd2, 0, 0, 32'h41);
    check("R8 char type", {31'b0, print_is_char}, 1);
    r30_val = 32'h99;
    repeat (3) begin
      instr_valid = 1;
      @(posedge clk); @(negedge clk);
    end
    instr_valid = 0;
    check("R9 held valid", {31'b0, print_valid}, 1);
    check("R9 held data", print_data, 32'h41);
    check("R9 ready low", {31'b0, instr_ready}, 0);
    check("R9 pc frozen", pc, 302);
    print_ready = 1;
    #1;
    check("R9 ready back", {31'b0, instr_ready}, 1);
    @(posedge clk); @(negedge clk);
    check("R9 drained", {31'b0, print_valid}, 0);
  endtask

  task automatic t_undef;
    issue(5'd6, 0, 0, 22'd500, 0, 0);
    issue(5'd26, 0, 0, 0, 0, 0);
    check("R10 op26 illegal", {31'b0, s_ill}, 1);
    check("R10 op26 step", pc, 501);
    issue(5'd31, 12'd23, 0, 0, 0, 0);
    check("R10 xop23 illegal", {31'b0, s_ill}, 1);
    issue(5'd31, 12'd22, 0, 0, 0, 0);
    check("R10 xop22 legal", {31'b0, s_ill}, 0);
    issue(5'd31, 12'd19, 5'd3, 0, 0, 0);
    check("R10 trap3 illegal", {31'b0, s_ill}, 1);
    check("R10 no print", {31'b0, print_valid}, 0);
    check("R10 no halt", {31'b0, halt}, 0);
    check("R10 pc", pc, 504);
  endtask

  task automatic t_halt;
    issue(5'd31, 12'd19, 5'd0, 0, 0, 0);
    check("R7 halt set", {31'b0, halt}, 1);
    check("R7 pc kept", pc, 504);
    issue(5'd6, 0, 0, 22'd9, 0, 0);
    check("R7 pc frozen", pc, 504);
    check("R7 ready low", {31'b0, instr_ready}, 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_seq;
    t_jump;
    t_call;
    t_branch;
    t_return;
    t_print;
    t_undef;
    t_halt;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule